// File: doc/BRIEF.md
# Latched Scan Counter

This block counts falling edges on slow external count lines and reports the result one byte at a time over a shared 8-bit bus. A mode input sets its shape. It runs either as a single 32-bit counter or as two separate 16-bit counters. Each counter watches a pair of alternative count lines. The effective count signal of a counter is the OR of its pair. A high level on either line therefore holds that OR high and blocks counting. The lines are brought into the system clock domain through a two-stage synchroniser, and each counter advances at most once per clock.

Software or a controller captures a snapshot of the live count into a latch bank with a load strobe. It then walks the snapshot out with scan strobes. Several of these blocks can share one bus. The cascade output of one block feeds the cascade input of the next. When a block has presented its last byte, it lets go of the bus and raises its cascade output. The next block then follows on with its own bytes, driven by the same scan strobes.

Top module: `latch_scan_counter`

## Requirements
- R1: A counter advances by exactly one for each high-to-low transition of the OR of its two count lines, observed after a two-flop synchroniser.
- R2: While either line of a counter's pair is held high, pulses on the other line of that pair do not change the count.
- R3: With split_i low, the A line pair drives one 32-bit count, and a wrap of the low 16 bits carries into the high 16 bits. The B lines have no effect in this mode.
- R4: With split_i high, counter A (bits 15:0 of the snapshot) follows the A lines and counter B (bits 31:16) follows the B lines. There is no carry between them.
- R5: A count at all ones returns to all zeros on its next increment.
- R6: While rst_ni is low, counts, snapshot and byte pointer are cleared, and oe_o, cas_o and data_o are all low.
- R7: When load_i is high at a clock edge, the live count is copied into the snapshot. Otherwise the snapshot holds, also during readout, and counting continues whatever the readout state.
- R8: With cas_i high, the first scan_i strobe presents snapshot byte 0 (bits 7:0) with oe_o high. The next three strobes present bytes 1, 2 and 3 in turn. In split mode this order is A low, A high, B low, B high.
- R9: The fifth strobe drops oe_o and raises cas_o. cas_o stays high while cas_i stays high. Scan strobes with cas_i low are ignored.
- R10: cas_i low returns the scanner to idle on the next clock, with oe_o and cas_o low. data_o reads zero whenever oe_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| split_i | input | 1 | 0: one 32-bit counter, 1: two 16-bit counters |
| cnt_a_i | input | 2 | Alternative count lines of counter A |
| cnt_b_i | input | 2 | Alternative count lines of counter B |
| load_i | input | 1 | Copy the live count into the snapshot |
| scan_i | input | 1 | Scan strobe, one byte step per high cycle |
| cas_i | input | 1 | Cascade enable from the previous device |
| data_o | output | 8 | Presented snapshot byte |
| oe_o | output | 1 | Bus drive enable (high-impedance when low) |
| cas_o | output | 1 | Cascade enable to the next device |

## Verification
Some rules are checked by assertions on every cycle. The low count moves only by one step, with wrap. The snapshot moves only on a load. The bus is never enabled while the cascade output is high, and data is zero when the bus is released. Loss of cascade input always idles the scanner, and the bus only turns on after a scan strobe under cascade. Other behaviour shows only in the bench scenarios: the exact byte order, mode-dependent routing of the B lines, blocking by a held line, carry from the low to the high half, and the snapshot staying fixed while counting goes on.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
  typedef enum logic [1:0] {
    SC_IDLE = 2'd0,
    SC_SHOW = 2'd1,
    SC_PASS = 2'd2
  } scan_state_e;
endpackage

// File: rtl/lsc_edge_sync.sv
module lsc_edge_sync #(
  parameter int unsigned N_IN   = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_IN-1:0] raw_i,
  output logic            fall_o
);
  // chain of STAGES sync flops plus one history flop
  logic [STAGES:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-1:0], |raw_i};
  end

  assign fall_o = chain_q[STAGES] & ~chain_q[STAGES-1];
endmodule

// File: rtl/lsc_count_core.sv
module lsc_count_core #(
  parameter int unsigned HALF_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              split_i,
  input  logic              inc_a_i,
  input  logic              inc_b_i,
  output logic [HALF_W-1:0] lo_o,
  output logic [HALF_W-1:0] hi_o
);
  logic [HALF_W-1:0] lo_q, hi_q;
  logic carry, hi_inc;

  assign carry  = inc_a_i & (&lo_q);
  assign hi_inc = split_i ? inc_b_i : carry;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (inc_a_i) lo_q <= lo_q + 1'b1;
      if (hi_inc)  hi_q <= hi_q + 1'b1;
    end
  end

  assign lo_o = lo_q;
  assign hi_o = hi_q;
endmodule

// File: rtl/lsc_byte_scan.sv
module lsc_byte_scan
  import lsc_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scan_i,
  input  logic             cas_i,
  input  logic [WIDTH-1:0] snap_i,
  output logic [7:0]       data_o,
  output logic             oe_o,
  output logic             cas_o
);
  localparam int unsigned NB    = WIDTH / 8;
  localparam int unsigned PTR_W = (NB > 1) ? $clog2(NB) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(NB - 1);

  scan_state_e state_q;
  logic [PTR_W-1:0] ptr_q;
  logic [7:0] bytes [NB];

  for (genvar g = 0; g < NB; g++) begin : g_bytes
    assign bytes[g] = snap_i[8*g +: 8];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SC_IDLE;
      ptr_q   <= '0;
    end else if (!cas_i) begin
      state_q <= SC_IDLE;
      ptr_q   <= '0;
    end else if (scan_i) begin
      unique case (state_q)
        SC_IDLE: begin
          state_q <= SC_SHOW;
          ptr_q   <= '0;
        end
        SC_SHOW: begin
          if (ptr_q == LAST) state_q <= SC_PASS;
          else               ptr_q   <= ptr_q + 1'b1;
        end
        default: state_q <= SC_PASS;
      endcase
    end
  end

  assign oe_o   = (state_q == SC_SHOW);
  assign cas_o  = (state_q == SC_PASS);
  assign data_o = oe_o ? bytes[ptr_q] : 8'h00;
endmodule

// File: rtl/latch_scan_counter.sv
module latch_scan_counter #(
  parameter int unsigned HALF_W = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       split_i,
  input  logic [1:0] cnt_a_i,
  input  logic [1:0] cnt_b_i,
  input  logic       load_i,
  input  logic       scan_i,
  input  logic       cas_i,
  output logic [7:0] data_o,
  output logic       oe_o,
  output logic       cas_o
);
  localparam int unsigned WIDTH = 2 * HALF_W;

  logic fall_a, fall_b;
  logic [HALF_W-1:0] lo_q, hi_q;
  logic [WIDTH-1:0]  snap_q;

  lsc_edge_sync #(.N_IN(2), .STAGES(STAGES)) u_sync_a (
    .clk_i(clk_i), .rst_ni(rst_ni), .raw_i(cnt_a_i), .fall_o(fall_a)
  );
  lsc_edge_sync #(.N_IN(2), .STAGES(STAGES)) u_sync_b (
    .clk_i(clk_i), .rst_ni(rst_ni), .raw_i(cnt_b_i), .fall_o(fall_b)
  );

  lsc_count_core #(.HALF_W(HALF_W)) u_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .split_i(split_i),
    .inc_a_i(fall_a), .inc_b_i(fall_b), .lo_o(lo_q), .hi_o(hi_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     snap_q <= '0;
    else if (load_i) snap_q <= {hi_q, lo_q};
  end

  lsc_byte_scan #(.WIDTH(WIDTH)) u_scan (
    .clk_i(clk_i), .rst_ni(rst_ni), .scan_i(scan_i), .cas_i(cas_i),
    .snap_i(snap_q), .data_o(data_o), .oe_o(oe_o), .cas_o(cas_o)
  );
endmodule

// File: rtl/lsc_chk.sv
module lsc_chk #(
  parameter int unsigned HALF_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              load_i,
  input logic              scan_i,
  input logic              cas_i,
  input logic              oe_o,
  input logic              cas_o,
  input logic [7:0]        data_o,
  input logic [2*HALF_W-1:0] snap_i,
  input logic [HALF_W-1:0] lo_i
);
  // R1 R5
  lo_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lo_i != $past(lo_i)) |-> (lo_i == HALF_W'($past(lo_i) + 1'b1)));

  // R7
  snap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(snap_i));

  // R9
  bus_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(oe_o && cas_o));

  // R10
  idle_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cas_i |=> (!oe_o && !cas_o));

  // R10
  quiet_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_o |-> (data_o == 8'h00));

  // R8
  oe_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_o) |-> ($past(scan_i) && $past(cas_i)));
endmodule

bind latch_scan_counter lsc_chk #(.HALF_W(HALF_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i), .scan_i(scan_i),
  .cas_i(cas_i), .oe_o(oe_o), .cas_o(cas_o), .data_o(data_o),
  .snap_i(snap_q), .lo_i(lo_q)
);

// File: tb/sim_latch_scan_counter.sv
module sim_latch_scan_counter;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic split_i = 1'b0;
  logic [1:0] cnt_a_i = '0, cnt_b_i = '0;
  logic load_i = 1'b0, scan_i = 1'b0, cas_i = 1'b0;
  logic [7:0] data_o;
  logic oe_o, cas_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  latch_scan_counter u0 (
    .clk_i(clk), .rst_ni(rst_ni), .split_i(split_i), .cnt_a_i(cnt_a_i),
    .cnt_b_i(cnt_b_i), .load_i(load_i), .scan_i(scan_i), .cas_i(cas_i),
    .data_o(data_o), .oe_o(oe_o), .cas_o(cas_o)
  );

  // {split, blk_a, blk_b, pulses_a, pulses_b}
  localparam logic [18:0] VEC [7] = '{
    {1'b0, 1'b0, 1'b0, 8'd5,   8'd3},
    {1'b0, 1'b0, 1'b0, 8'd0,   8'd0},
    {1'b1, 1'b0, 1'b0, 8'd7,   8'd2},
    {1'b1, 1'b1, 1'b0, 8'd4,   8'd3},
    {1'b1, 1'b0, 1'b1, 8'd9,   8'd6},
    {1'b0, 1'b1, 1'b0, 8'd6,   8'd0},
    {1'b1, 1'b0, 1'b0, 8'd255, 8'd17}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    cnt_a_i = '0; cnt_b_i = '0; load_i = 1'b0; scan_i = 1'b0; cas_i = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulses(input int na, input int nb);
    int n;
    n = (na > nb) ? na : nb;
    for (int i = 0; i < n; i++) begin
      cnt_a_i[0] = (i < na);
      cnt_b_i[0] = (i < nb);
      repeat (2) @(negedge clk);
      cnt_a_i[0] = 1'b0;
      cnt_b_i[0] = 1'b0;
      repeat (2) @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic load();
    load_i = 1'b1;
    @(negedge clk);
    load_i = 1'b0;
  endtask

  task automatic strobe();
    scan_i = 1'b1;
    @(negedge clk);
    scan_i = 1'b0;
  endtask

  task automatic read_all(input logic [31:0] exp, input string req);
    cas_i = 1'b1;
    for (int k = 0; k < 4; k++) begin
      strobe();
      check(oe_o === 1'b1 && data_o === exp[8*k +: 8], req,
            {23'd0, oe_o, data_o}, {23'd0, 1'b1, exp[8*k +: 8]});
    end
    strobe();
    check(oe_o === 1'b0 && cas_o === 1'b1, "R9 pass", {oe_o, cas_o}, 32'd1);
    cas_i = 1'b0;
    @(negedge clk);
    check(cas_o === 1'b0 && oe_o === 1'b0 && data_o === 8'h00, "R10 idle",
          {cas_o, oe_o, data_o}, 32'd0);
  endtask

  initial begin
    logic [31:0] exp;
    logic [18:0] v;
    logic [15:0] lo_e, hi_e;
    do_reset();
    // R6 reset state
    check(oe_o === 1'b0 && cas_o === 1'b0 && data_o === 8'h00, "R6 reset",
          {oe_o, cas_o, data_o}, 32'd0);

    for (int t = 0; t < 7; t++) begin
      v = VEC[t];
      do_reset();
      split_i = v[18];
      cnt_a_i[1] = v[17];
      cnt_b_i[1] = v[16];
      @(negedge clk);
      pulses(int'(v[15:8]), int'(v[7:0]));
      lo_e = v[17] ? 16'd0 : {8'd0, v[15:8]};
      hi_e = (v[18] && !v[16]) ? {8'd0, v[7:0]} : 16'd0; // R3 B ignored, R4 split
      exp = {hi_e, lo_e};
      load();
      read_all(exp, v[17] | v[16] ? "R2 blocked" : (v[18] ? "R4 split" : "R3 wide"));
    end

    // R7 snapshot holds while counting continues
    do_reset();
    split_i = 1'b0;
    pulses(3, 0);
    load();
    pulses(2, 0);
    read_all(32'd3, "R7 hold");
    load();
    read_all(32'd5, "R7 reload");

    // R7 load during readout replaces presented byte
    cas_i = 1'b1;
    strobe();
    check(data_o === 8'd5, "R7 pre", {24'd0, data_o}, 32'd5);
    pulses(1, 0);
    load();
    check(oe_o === 1'b1 && data_o === 8'd6, "R7 mid-read", {23'd0, oe_o, data_o},
          {23'd0, 1'b1, 8'd6});
    // R6 reset mid-readout
    rst_ni = 1'b0;
    #1;
    check(oe_o === 1'b0 && data_o === 8'h00, "R6 async", {oe_o, data_o}, 32'd0);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R9 scan ignored without cascade; cas_o stays while cas_i stays
    cas_i = 1'b0;
    strobe();
    check(oe_o === 1'b0, "R9 no-cas", {31'd0, oe_o}, 32'd0);
    cas_i = 1'b1;
    repeat (5) strobe();
    strobe();
    check(cas_o === 1'b1 && oe_o === 1'b0, "R9 hold", {cas_o, oe_o}, 32'd2);
    cas_i = 1'b0;
    @(negedge clk);

    // R5 low half wraps, R3 carry into high half
    do_reset();
    split_i = 1'b0;
    for (int i = 0; i < 65536; i++) begin
      cnt_a_i[0] = 1'b1;
      @(negedge clk);
      cnt_a_i[0] = 1'b0;
      @(negedge clk);
    end
    repeat (4) @(negedge clk);
    load();
    read_all(32'h0001_0000, "R5 wrap");
    // R1 single step after wrap
    pulses(1, 0);
    load();
    read_all(32'h0001_0001, "R1 step");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule